// File: doc/BRIEF.md
# Debug Register File Access Unit

This block keeps the eight debug-register slots that an instruction-execution front end reads and writes by a 3-bit index. There are four breakpoint address registers, one status register and one control register. Two indices in the upper half are reserved. While the debug-extensions input is low, they mirror the status and control registers. While it is high, any access to them is refused with an illegal-opcode fault, and that access changes no register.

The stored values of the status and control registers always keep a fixed set of bits high. Every write to either register ORs that register's mask into the value. A control write also sends a one-cycle reprogram pulse, so that the breakpoint match logic knows to reload its configuration. A single-step event from the execution core sets the single-step flag in the status register and produces a one-cycle debug-exception request.

Reads are answered in the same cycle as the request. Fault, reprogram and exception pulses are registered and appear in the cycle after the event that causes them.

Top module: `dbg_regfile_unit`

## Requirements
- R1: After reset, all four address registers read 0x00000000, the status register reads 0xFFFF0FF0 and the control register reads 0x00000400. The fault, reprogram and exception outputs are low.
- R2: Indices 0 to 3 read and write address registers 0 to 3. The full 32-bit value is stored with no masking.
- R3: Index 6 reads the status register. A write to index 6 stores the write data ORed with 0xFFFF0FF0.
- R4: Index 7 reads the control register. A write to index 7 stores the write data ORed with 0x00000400.
- R5: While `dbg_ext_en` is low, index 4 acts exactly like index 6 and index 5 acts exactly like index 7, for both reads and writes, and with the same masks.
- R6: While `dbg_ext_en` is high, an access to index 4 or 5 modifies no register. A read of either index returns zero.
- R7: A read request raises `rd_valid` and drives `rd_data` combinationally in the same cycle. A write request keeps `rd_valid` low.
- R8: `fault_pulse` is high for exactly the one cycle after each refused access. It is low in the cycle after any allowed access or idle cycle.
- R9: `reprogram_pulse` is high for the one cycle after each accepted control-register write, whether through index 7 or index 5. It is low after every other kind of request.
- R10: A cycle with `step_evt` high sets status bit 14 at the next clock edge and leaves the other status bits unchanged. `dbg_exc_req` is high for the one following cycle. When a status write falls in the same cycle, the stored value is the masked write data with bit 14 also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 3 | Debug register index 0 to 7 |
| req_wdata | input | 32 | Write data |
| dbg_ext_en | input | 1 | Debug-extensions enable; high makes indices 4 and 5 fault |
| step_evt | input | 1 | Single-step event |
| rd_valid | output | 1 | Read data valid (combinational) |
| rd_data | output | 32 | Read data; zero when not a valid allowed read |
| fault_pulse | output | 1 | Illegal-opcode fault, one cycle after the request |
| reprogram_pulse | output | 1 | Control register was written, one cycle later |
| dbg_exc_req | output | 1 | Debug exception request, one cycle after a step |

## Verification
The hardest case to reach from the ports is a single-step event that falls in the same cycle as a status-register write. Here the OR of the step flag has to stack on top of the masked write data instead of being lost to it. A related case pairs a step with a refused alias write, where the status register must still take the step bit. The bench drives `step_evt` and the write request together in directed cycles and then reads the status back through index 6. Alias behaviour is covered by running the same table of index 4 and 5 accesses with the extensions input both low and high.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  // Which storage an index resolves to after the alias/fault rules.
  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_STAT  = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_FAULT = 2'd3
  } dbg_sel_e;

  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_NUM_ADDR = 4;
  localparam logic [31:0] DEF_STAT_ONE = 32'hFFFF_0FF0;
  localparam logic [31:0] DEF_CTRL_ONE = 32'h0000_0400;
  localparam int unsigned DEF_STEP_BIT = 14;
endpackage

// File: rtl/dbg_decode.sv
// Resolves a register index into a storage select, applying the
// alias/fault rules for the first two upper-half indices.
module dbg_decode
  import dbg_pkg::*;
#(
  parameter int unsigned NUM_ADDR = 4,
  localparam int unsigned AW      = $clog2(NUM_ADDR),
  localparam int unsigned IDX_W   = AW + 1
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             ext_en,
  output dbg_sel_e         sel,
  output logic [AW-1:0]    slot
);
  logic [AW-1:0] ofs;

  always_comb begin
    ofs  = idx[AW-1:0];
    slot = ofs;
    if (!idx[IDX_W-1]) begin
      sel = SEL_ADDR;
    end else if (ofs == AW'(0)) begin
      sel = ext_en ? SEL_FAULT : SEL_STAT;
    end else if (ofs == AW'(1)) begin
      sel = ext_en ? SEL_FAULT : SEL_CTRL;
    end else if (ofs == AW'(2)) begin
      sel = SEL_STAT;
    end else if (ofs == AW'(3)) begin
      sel = SEL_CTRL;
    end else begin
      sel = SEL_FAULT;
    end
  end
endmodule

// File: rtl/dbg_addr_bank.sv
// Breakpoint address registers, one enabled flop bank per slot.
module dbg_addr_bank #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_ADDR = 4,
  localparam int unsigned AW      = $clog2(NUM_ADDR)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [AW-1:0]                  slot,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NUM_ADDR-1:0][DATA_W-1:0] regs_o
);
  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_slot
    logic              en;
    logic [DATA_W-1:0] q;

    always_comb en = we && (slot == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= wdata;
      end
    end

    assign regs_o[g] = q;
  end
endmodule

// File: rtl/dbg_sc_regs.sv
// Status and control registers with fixed-one masks and step flag.
module dbg_sc_regs #(
  parameter int unsigned       DATA_W   = 32,
  parameter logic [DATA_W-1:0] STAT_ONE = 32'hFFFF_0FF0,
  parameter logic [DATA_W-1:0] CTRL_ONE = 32'h0000_0400,
  parameter int unsigned       STEP_BIT = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_we,
  input  logic              ctrl_we,
  input  logic              step,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] ctrl_o
);
  logic [DATA_W-1:0] stat_d, ctrl_d;
  logic              stat_en, ctrl_en;

  always_comb begin
    stat_d = stat_o;
    if (stat_we) begin
      stat_d = wdata | STAT_ONE;
    end
    if (step) begin
      stat_d[STEP_BIT] = 1'b1;
    end
    stat_en = stat_we || step;
    ctrl_d  = wdata | CTRL_ONE;
    ctrl_en = ctrl_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_o <= STAT_ONE;
    end else if (stat_en) begin
      stat_o <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o <= CTRL_ONE;
    end else if (ctrl_en) begin
      ctrl_o <= ctrl_d;
    end
  end
endmodule

// File: rtl/dbg_regfile_unit.sv
module dbg_regfile_unit
  import dbg_pkg::*;
#(
  parameter int unsigned       DATA_W   = DEF_DATA_W,
  parameter int unsigned       NUM_ADDR = DEF_NUM_ADDR,
  parameter logic [DATA_W-1:0] STAT_ONE = DEF_STAT_ONE,
  parameter logic [DATA_W-1:0] CTRL_ONE = DEF_CTRL_ONE,
  parameter int unsigned       STEP_BIT = DEF_STEP_BIT,
  localparam int unsigned      AW       = $clog2(NUM_ADDR),
  localparam int unsigned      IDX_W    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              dbg_ext_en,
  input  logic              step_evt,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              fault_pulse,
  output logic              reprogram_pulse,
  output logic              dbg_exc_req
);
  dbg_sel_e                      sel;
  logic [AW-1:0]                 slot;
  logic                          refused, wr_ok, rd_req;
  logic                          addr_we, stat_we, ctrl_we;
  logic [NUM_ADDR-1:0][DATA_W-1:0] addr_q;
  logic [DATA_W-1:0]             stat_q, ctrl_q;
  logic                          fault_d, reprog_d, exc_d;

  dbg_decode #(.NUM_ADDR(NUM_ADDR)) u_dec (
    .idx    (req_index),
    .ext_en (dbg_ext_en),
    .sel    (sel),
    .slot   (slot)
  );

  always_comb begin
    refused = req_valid && (sel == SEL_FAULT);
    wr_ok   = req_valid && req_write && (sel != SEL_FAULT);
    rd_req  = req_valid && !req_write;
    addr_we = wr_ok && (sel == SEL_ADDR);
    stat_we = wr_ok && (sel == SEL_STAT);
    ctrl_we = wr_ok && (sel == SEL_CTRL);
  end

  dbg_addr_bank #(.DATA_W(DATA_W), .NUM_ADDR(NUM_ADDR)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (addr_we),
    .slot   (slot),
    .wdata  (req_wdata),
    .regs_o (addr_q)
  );

  dbg_sc_regs #(
    .DATA_W   (DATA_W),
    .STAT_ONE (STAT_ONE),
    .CTRL_ONE (CTRL_ONE),
    .STEP_BIT (STEP_BIT)
  ) u_sc (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_we (stat_we),
    .ctrl_we (ctrl_we),
    .step    (step_evt),
    .wdata   (req_wdata),
    .stat_o  (stat_q),
    .ctrl_o  (ctrl_q)
  );

  // Combinational read path.
  always_comb begin
    rd_valid = rd_req;
    rd_data  = '0;
    if (rd_req) begin
      unique case (sel)
        SEL_ADDR:  rd_data = addr_q[slot];
        SEL_STAT:  rd_data = stat_q;
        SEL_CTRL:  rd_data = ctrl_q;
        default:   rd_data = '0;
      endcase
    end
  end

  // Registered one-cycle event pulses.
  always_comb begin
    fault_d  = refused;
    reprog_d = ctrl_we;
    exc_d    = step_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_pulse     <= 1'b0;
      reprogram_pulse <= 1'b0;
      dbg_exc_req     <= 1'b0;
    end else begin
      fault_pulse     <= fault_d;
      reprogram_pulse <= reprog_d;
      dbg_exc_req     <= exc_d;
    end
  end
endmodule

// File: rtl/dbg_regfile_unit_chk.sv
module dbg_regfile_unit_chk #(
  parameter int unsigned  DATA_W   = 32,
  parameter int unsigned  NUM_ADDR = 4,
  parameter int unsigned  STEP_BIT = 14,
  localparam int unsigned AW       = $clog2(NUM_ADDR),
  localparam int unsigned IDX_W    = AW + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [IDX_W-1:0]  req_index,
  input logic              dbg_ext_en,
  input logic              step_evt,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              fault_pulse,
  input logic              reprogram_pulse,
  input logic              dbg_exc_req,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] ctrl_q
);
  localparam logic [IDX_W-1:0] IX_AS = IDX_W'(NUM_ADDR);
  localparam logic [IDX_W-1:0] IX_AC = IDX_W'(NUM_ADDR + 1);
  localparam logic [IDX_W-1:0] IX_C  = IDX_W'(NUM_ADDR + 3);

  logic bad;
  always_comb bad = req_valid && dbg_ext_en &&
                    ((req_index == IX_AS) || (req_index == IX_AC));

  a_r6_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !step_evt) |=> ($stable(stat_q) && $stable(ctrl_q)));

  a_r6_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !req_write) |-> (rd_data == '0));

  a_r8_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> fault_pulse);

  a_r8_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bad |=> !fault_pulse);

  a_r9_reprogram: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (req_index == IX_C)) |=> reprogram_pulse);

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> !reprogram_pulse);

  a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (stat_q[STEP_BIT] && dbg_exc_req));

  a_r7_no_rd_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> !rd_valid);
endmodule

bind dbg_regfile_unit dbg_regfile_unit_chk #(
  .DATA_W   (DATA_W),
  .NUM_ADDR (NUM_ADDR),
  .STEP_BIT (STEP_BIT)
) u_chk (.*);

// File: tb/dbg_regfile_unit_test.sv
module dbg_regfile_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, dbg_ext_en, step_evt;
  logic [2:0]  req_index;
  logic [31:0] req_wdata;
  logic        rd_valid, fault_pulse, reprogram_pulse, dbg_exc_req;
  logic [31:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dbg_regfile_unit uut (
    .clk, .rst_n, .req_valid, .req_write, .req_index, .req_wdata,
    .dbg_ext_en, .step_evt, .rd_valid, .rd_data, .fault_pulse,
    .reprogram_pulse, .dbg_exc_req
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Captured results of one request cycle.
  logic        c_rv, c_fp, c_rp, c_xr;
  logic [31:0] c_rd;

  task automatic cyc(input logic wr, input logic ext, input logic [2:0] idx,
                     input logic [31:0] wd, input logic stp);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; dbg_ext_en = ext;
    req_index = idx; req_wdata = wd; step_evt = stp;
    #1;
    c_rv = rd_valid; c_rd = rd_data;
    @(posedge clk);
    #1;
    c_fp = fault_pulse; c_rp = reprogram_pulse; c_xr = dbg_exc_req;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; step_evt = 1'b0;
    @(posedge clk);
    #1;
    c_fp = fault_pulse; c_rp = reprogram_pulse; c_xr = dbg_exc_req;
  endtask

  // {tag[74:71], wr, ext, idx[2:0], wdata[31:0], exp_rd[31:0], exp_fault, exp_rep}
  localparam int NV = 23;
  localparam logic [74:0] VEC [0:NV-1] = '{
    {4'd2,  1'b1, 1'b0, 3'd0, 32'h1234_5678, 32'h0,          1'b0, 1'b0}, // R2
    {4'd2,  1'b0, 1'b0, 3'd0, 32'h0,          32'h1234_5678, 1'b0, 1'b0}, // R2
    {4'd2,  1'b1, 1'b0, 3'd3, 32'hDEAD_BEEF, 32'h0,          1'b0, 1'b0}, // R2
    {4'd2,  1'b0, 1'b0, 3'd3, 32'h0,          32'hDEAD_BEEF, 1'b0, 1'b0}, // R2
    {4'd2,  1'b0, 1'b0, 3'd1, 32'h0,          32'h0,          1'b0, 1'b0}, // R2
    {4'd3,  1'b1, 1'b0, 3'd6, 32'h0000_0001, 32'h0,          1'b0, 1'b0}, // R3
    {4'd3,  1'b0, 1'b0, 3'd6, 32'h0,          32'hFFFF_0FF1, 1'b0, 1'b0}, // R3
    {4'd5,  1'b0, 1'b0, 3'd4, 32'h0,          32'hFFFF_0FF1, 1'b0, 1'b0}, // R5
    {4'd5,  1'b1, 1'b0, 3'd4, 32'h0000_A000, 32'h0,          1'b0, 1'b0}, // R5
    {4'd5,  1'b0, 1'b0, 3'd6, 32'h0,          32'hFFFF_AFF0, 1'b0, 1'b0}, // R5
    {4'd4,  1'b1, 1'b0, 3'd7, 32'h0000_0003, 32'h0,          1'b0, 1'b1}, // R4 R9
    {4'd4,  1'b0, 1'b0, 3'd7, 32'h0,          32'h0000_0403, 1'b0, 1'b0}, // R4
    {4'd9,  1'b1, 1'b0, 3'd5, 32'h000F_0000, 32'h0,          1'b0, 1'b1}, // R9 via alias
    {4'd5,  1'b0, 1'b0, 3'd5, 32'h0,          32'h000F_0400, 1'b0, 1'b0}, // R5
    {4'd6,  1'b1, 1'b1, 3'd5, 32'hFFFF_FFFF, 32'h0,          1'b1, 1'b0}, // R6 R8
    {4'd6,  1'b0, 1'b1, 3'd7, 32'h0,          32'h000F_0400, 1'b0, 1'b0}, // R6
    {4'd6,  1'b1, 1'b1, 3'd4, 32'h0,          32'h0,          1'b1, 1'b0}, // R6
    {4'd6,  1'b0, 1'b1, 3'd6, 32'h0,          32'hFFFF_AFF0, 1'b0, 1'b0}, // R6
    {4'd6,  1'b0, 1'b1, 3'd4, 32'h0,          32'h0,          1'b1, 1'b0}, // R6 R8
    {4'd8,  1'b0, 1'b1, 3'd5, 32'h0,          32'h0,          1'b1, 1'b0}, // R8
    {4'd4,  1'b1, 1'b1, 3'd7, 32'h0,          32'h0,          1'b0, 1'b1}, // R4
    {4'd4,  1'b0, 1'b1, 3'd7, 32'h0,          32'h0000_0400, 1'b0, 1'b0}, // R4
    {4'd7,  1'b0, 1'b1, 3'd3, 32'h0,          32'hDEAD_BEEF, 1'b0, 1'b0}  // R7
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_index = '0;
    req_wdata = '0; dbg_ext_en = 1'b0; step_evt = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: pulses low during reset
    chk("R1 fault in reset", {31'h0, fault_pulse}, 32'h0);
    chk("R1 reprog in reset", {31'h0, reprogram_pulse}, 32'h0);
    chk("R1 exc in reset", {31'h0, dbg_exc_req}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset contents through every index
    for (int i = 0; i < 8; i++) begin
      logic [31:0] e;
      e = (i == 4 || i == 6) ? 32'hFFFF_0FF0 : (i == 5 || i == 7) ? 32'h0000_0400 : 32'h0;
      cyc(1'b0, 1'b0, 3'(i), 32'h0, 1'b0);
      chk($sformatf("R1 reset read idx %0d", i), c_rd, e);
      chk("R7 rd_valid on read", {31'h0, c_rv}, 32'h1);
    end

    // Table walk
    for (int v = 0; v < NV; v++) begin
      logic [74:0] t;
      string tg;
      t = VEC[v];
      tg = $sformatf("R%0d vec %0d", t[74:71], v);
      cyc(t[70], t[69], t[68:66], t[65:34], 1'b0);
      if (!t[70]) chk({tg, " rd_data"}, c_rd, t[33:2]);
      chk({tg, " rd_valid (R7)"}, {31'h0, c_rv}, {31'h0, !t[70]});
      chk({tg, " fault (R8)"}, {31'h0, c_fp}, {31'h0, t[1]});
      chk({tg, " reprog (R9)"}, {31'h0, c_rp}, {31'h0, t[0]});
    end
    idle();
    chk("R8 fault drops after idle", {31'h0, c_fp}, 32'h0);

    // R10: step alone sets bit 14, exc pulse one cycle
    cyc(1'b0, 1'b0, 3'd0, 32'h0, 1'b1);
    chk("R10 exc req after step", {31'h0, c_xr}, 32'h1);
    idle();
    chk("R10 exc req one cycle", {31'h0, c_xr}, 32'h0);
    cyc(1'b0, 1'b0, 3'd6, 32'h0, 1'b0);
    chk("R10 step bit set", c_rd, 32'hFFFF_EFF0);

    // R10: step together with status write
    cyc(1'b1, 1'b0, 3'd6, 32'h0, 1'b1);
    idle();
    cyc(1'b0, 1'b0, 3'd6, 32'h0, 1'b0);
    chk("R10 step with write", c_rd, 32'hFFFF_4FF0);

    // R6 + R10: refused alias write with step keeps step bit
    cyc(1'b1, 1'b0, 3'd6, 32'h0, 1'b0);
    cyc(1'b1, 1'b1, 3'd4, 32'h0000_0001, 1'b1);
    chk("R6 refused with step fault", {31'h0, c_fp}, 32'h1);
    cyc(1'b0, 1'b1, 3'd6, 32'h0, 1'b0);
    chk("R6 refused with step status", c_rd, 32'hFFFF_4FF0);

    // R1: reset again mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cyc(1'b0, 1'b0, 3'd3, 32'h0, 1'b0);
    chk("R1 addr cleared by reset", c_rd, 32'h0);
    cyc(1'b0, 1'b0, 3'd6, 32'h0, 1'b0);
    chk("R1 status after reset", c_rd, 32'hFFFF_0FF0);
    idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule